// File: doc/BRIEF.md
# Command Word Pusher with Error Suspend

This block sits between a command-stream decoder and a command queue. The decoder hands it the current method address, subchannel and a hold flag, then streams the data words that belong to that method. For every data word accepted, the pusher writes one queue entry that carries the method address, subchannel, hold flag and the word itself as the parameter. After each entry it moves the method address on by four bytes, unless the hold flag is set, in which case every word goes to the same method.

When the upstream logic reports a nonzero error code, the pusher stops. It enters a suspended state and raises a pending interrupt. It stays stopped until software writes the push control register with the suspend status bit clear. The control readback shows the access enable, whether the queue is empty, and the suspend status. The most recent word can be read from a shadow register, and a counter records how many words have been pushed. When the queue is full, the pusher holds the data input off with a ready signal and drops nothing.

Top module: `cmd_pusher`

## Requirements
- R1: After reset the access enable, suspend status, pending interrupt, word count, shadow word and loaded method are all zero, and `word_ready` is low.
- R2: When `word_valid` and `word_ready` are both high in a cycle, `q_wr` is high in that same cycle. `q_method`, `q_subch` and `q_hold` then carry the current method state and `q_param` carries `word_data`.
- R3: After each accepted word with the hold flag clear, the method address grows by 4 modulo 2^MW. A method of 0x3FFC is followed by 0x0000 at the default width.
- R4: With the hold flag set, every accepted word uses the same method address.
- R5: `word_ready` is low and `q_wr` never rises while `push_en` is low, while the access enable is 0, or while the pusher is suspended.
- R6: `err_valid` with a nonzero `err_code` sets the suspend status and the pending interrupt on the next edge. A zero code has no effect.
- R7: `ctrl_rdata` shows the access enable at bit 0, `q_empty` at bit 8 and the suspend status at bit 12. All other bits read as zero.
- R8: A `csr_wr` loads bit 0 of `csr_wdata` into the access enable and bit 12 into the suspend status. A write with bit 12 clear resumes a suspended pusher, and a write with bit 12 set forces suspend. If an error arrives in the same cycle, the error wins.
- R9: `shadow_word` holds the parameter of the most recently accepted word.
- R10: While `q_full` is high, `word_ready` is low and no entry is written. The offered word is accepted once `q_full` falls.
- R11: `word_count` increments by one for each accepted word and wraps at 2^CW.
- R12: `irq_clr` clears the pending interrupt. An error in the same cycle leaves it set, and clearing it does not change the suspend status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| push_en | input | 1 | Global push enable |
| hdr_load | input | 1 | Load new method state |
| hdr_method | input | MW | Method byte address to load |
| hdr_subch | input | SW | Subchannel to load |
| hdr_hold | input | 1 | Hold flag to load (method does not advance) |
| word_valid | input | 1 | Data word offered |
| word_data | input | DW | Data word |
| word_ready | output | 1 | Pusher takes the word this cycle |
| err_valid | input | 1 | Error report strobe |
| err_code | input | EW | Error code, nonzero means error |
| q_full | input | 1 | Queue cannot take an entry |
| q_empty | input | 1 | Queue holds no entries |
| q_wr | output | 1 | Queue write strobe |
| q_method | output | MW | Entry method address |
| q_subch | output | SW | Entry subchannel |
| q_hold | output | 1 | Entry hold flag |
| q_param | output | DW | Entry parameter |
| csr_wr | input | 1 | Push control register write |
| csr_wdata | input | 32 | Push control write data |
| ctrl_rdata | output | 32 | Push control readback |
| irq_pending | output | 1 | Pusher interrupt pending |
| irq_clr | input | 1 | Clear pending interrupt |
| shadow_word | output | DW | Last accepted word |
| word_count | output | CW | Accepted word count |

## Verification
Runs of words with the hold flag clear are compared with runs that have it set. Incrementing entries show a different address on every word and held entries show the same one. A run that starts at the top of the method space shows the wrap to zero. Words are offered while the queue is full, while push or access is off, and while suspended. In each case the bench checks that no entry appears and the count stays put, which separates a stall from a dropped word. An error with code zero, an error with a nonzero code, and resume and force-suspend writes separate the suspend path from the interrupt path. An error and an interrupt clear in the same cycle show which one takes priority.

// File: rtl/cmd_pusher_pkg.sv
package cmd_pusher_pkg;
  localparam int unsigned METHOD_STEP  = 4;
  localparam int unsigned CTRL_ACC_BIT = 0;
  localparam int unsigned CTRL_EMP_BIT = 8;
  localparam int unsigned CTRL_SUS_BIT = 12;

  // Next method address: unchanged when held, else advanced by one word.
  function automatic logic [31:0] step_addr(input logic [31:0] addr, input logic hold);
    return hold ? addr : addr + 32'(METHOD_STEP);
  endfunction

  // Assemble the push control readback word.
  function automatic logic [31:0] pack_ctrl(input logic acc, input logic emp, input logic sus);
    logic [31:0] r;
    r = '0;
    r[CTRL_ACC_BIT] = acc;
    r[CTRL_EMP_BIT] = emp;
    r[CTRL_SUS_BIT] = sus;
    return r;
  endfunction
endpackage

// File: rtl/cmd_pusher_ctl.sv
module cmd_pusher_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic push_en,
  input  logic csr_wr,
  input  logic csr_acc,
  input  logic csr_sus,
  input  logic err_evt,
  input  logic irq_clr,
  output logic acc_o,
  output logic sus_o,
  output logic irq_o,
  output logic go_o
);
  logic acc_q, sus_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      sus_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (csr_wr) acc_q <= csr_acc;
      if (err_evt)     sus_q <= 1'b1;
      else if (csr_wr) sus_q <= csr_sus;
      if (err_evt)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign acc_o = acc_q;
  assign sus_o = sus_q;
  assign irq_o = irq_q;
  assign go_o  = push_en & acc_q & ~sus_q;

  // R6
  err_suspends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (sus_q && irq_q));
  // R8
  sus_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_q) |-> ($past(err_evt) || $past(csr_wr)));
  // R12
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(err_evt));
endmodule

// File: rtl/cmd_pusher_track.sv
module cmd_pusher_track #(
  parameter int unsigned MW = 14,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] ld_method,
  input  logic [SW-1:0] ld_subch,
  input  logic          ld_hold,
  input  logic          adv,
  output logic [MW-1:0] method_o,
  output logic [SW-1:0] subch_o,
  output logic          hold_o
);
  import cmd_pusher_pkg::*;

  logic [MW-1:0] method_q;
  logic [SW-1:0] subch_q;
  logic          hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      method_q <= '0;
      subch_q  <= '0;
      hold_q   <= 1'b0;
    end else if (load) begin
      method_q <= ld_method;
      subch_q  <= ld_subch;
      hold_q   <= ld_hold;
    end else if (adv) begin
      method_q <= MW'(step_addr(32'(method_q), hold_q));
    end
  end

  assign method_o = method_q;
  assign subch_o  = subch_q;
  assign hold_o   = hold_q;

  // R4
  hold_keeps_method_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && hold_q) |=> $stable(method_q));
  // R3
  incr_moves_method_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !hold_q) |=> (method_q != $past(method_q)));
endmodule

// File: rtl/cmd_pusher_hist.sv
module cmd_pusher_hist #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] shadow_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] shadow_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      count_q  <= '0;
    end else if (take) begin
      shadow_q <= data;
      count_q  <= count_q + CW'(1);
    end
  end

  assign shadow_o = shadow_q;
  assign count_o  = count_q;

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (count_q == $past(count_q) + CW'(1)));
  // R11
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(count_q));
  // R9
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (shadow_q == $past(data)));
endmodule

// File: rtl/cmd_pusher.sv
module cmd_pusher #(
  parameter int unsigned MW = 14,
  parameter int unsigned SW = 3,
  parameter int unsigned DW = 32,
  parameter int unsigned EW = 3,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          hdr_load,
  input  logic [MW-1:0] hdr_method,
  input  logic [SW-1:0] hdr_subch,
  input  logic          hdr_hold,
  input  logic          word_valid,
  input  logic [DW-1:0] word_data,
  output logic          word_ready,
  input  logic          err_valid,
  input  logic [EW-1:0] err_code,
  input  logic          q_full,
  input  logic          q_empty,
  output logic          q_wr,
  output logic [MW-1:0] q_method,
  output logic [SW-1:0] q_subch,
  output logic          q_hold,
  output logic [DW-1:0] q_param,
  input  logic          csr_wr,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   ctrl_rdata,
  output logic          irq_pending,
  input  logic          irq_clr,
  output logic [DW-1:0] shadow_word,
  output logic [CW-1:0] word_count
);
  import cmd_pusher_pkg::*;

  logic go, acc, sus, accept, err_evt;
  logic unused_wbits;

  assign unused_wbits = ^{csr_wdata[31:CTRL_SUS_BIT+1], csr_wdata[CTRL_SUS_BIT-1:CTRL_ACC_BIT+1]};
  assign err_evt      = err_valid && (err_code != '0);

  cmd_pusher_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_en (push_en),
    .csr_wr  (csr_wr),
    .csr_acc (csr_wdata[CTRL_ACC_BIT]),
    .csr_sus (csr_wdata[CTRL_SUS_BIT]),
    .err_evt (err_evt),
    .irq_clr (irq_clr),
    .acc_o   (acc),
    .sus_o   (sus),
    .irq_o   (irq_pending),
    .go_o    (go)
  );

  assign word_ready = go & ~q_full;
  assign accept     = word_valid & word_ready;

  cmd_pusher_track #(.MW(MW), .SW(SW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hdr_load),
    .ld_method (hdr_method),
    .ld_subch  (hdr_subch),
    .ld_hold   (hdr_hold),
    .adv       (accept),
    .method_o  (q_method),
    .subch_o   (q_subch),
    .hold_o    (q_hold)
  );

  cmd_pusher_hist #(.DW(DW), .CW(CW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .data     (word_data),
    .shadow_o (shadow_word),
    .count_o  (word_count)
  );

  assign q_wr       = accept;
  assign q_param    = word_data;
  assign ctrl_rdata = pack_ctrl(acc, q_empty, sus);

  // R10
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !q_wr);
  // R5
  no_write_when_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sus || !push_en || !acc) |-> !word_ready);
  // R2
  write_carries_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr |-> (q_param == word_data && word_valid));
endmodule

// File: tb/test_cmd_pusher.sv
module test_cmd_pusher;
  localparam int CLK_P = 10;
  localparam int MW = 14, SW = 3, DW = 32, EW = 3, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_en = 0, hdr_load = 0, hdr_hold = 0, word_valid = 0;
  logic [MW-1:0] hdr_method = '0;
  logic [SW-1:0] hdr_subch = '0;
  logic [DW-1:0] word_data = '0;
  logic err_valid = 0, q_full = 0, q_empty = 1, csr_wr = 0, irq_clr = 0;
  logic [EW-1:0] err_code = '0;
  logic [31:0] csr_wdata = '0;
  logic word_ready, q_wr, q_hold, irq_pending;
  logic [MW-1:0] q_method;
  logic [SW-1:0] q_subch;
  logic [DW-1:0] q_param, shadow_word;
  logic [31:0] ctrl_rdata;
  logic [CW-1:0] word_count;

  int checks = 0, errors = 0;
  int exp_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_pusher #(.MW(MW), .SW(SW), .DW(DW), .EW(EW), .CW(CW)) i_cmd_pusher (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .hdr_load(hdr_load),
    .hdr_method(hdr_method), .hdr_subch(hdr_subch), .hdr_hold(hdr_hold),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .err_valid(err_valid), .err_code(err_code), .q_full(q_full), .q_empty(q_empty),
    .q_wr(q_wr), .q_method(q_method), .q_subch(q_subch), .q_hold(q_hold),
    .q_param(q_param), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .ctrl_rdata(ctrl_rdata), .irq_pending(irq_pending), .irq_clr(irq_clr),
    .shadow_word(shadow_word), .word_count(word_count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic csr_write(input logic [31:0] v);
    csr_wr = 1; csr_wdata = v; tick(); csr_wr = 0; csr_wdata = '0;
  endtask

  task automatic load_hdr(input logic [MW-1:0] m, input logic [SW-1:0] s, input logic h);
    hdr_load = 1; hdr_method = m; hdr_subch = s; hdr_hold = h;
    tick(); hdr_load = 0;
  endtask

  // Offer one word expected to be taken; check the entry, then shadow and count.
  task automatic push_ok(input logic [DW-1:0] d, input logic [MW-1:0] em,
                         input logic [SW-1:0] es, input logic eh, input string req);
    word_valid = 1; word_data = d; #1;
    chk(q_wr === 1'b1, {req, " q_wr"}, 32'(q_wr), 1);
    chk(q_method === em, {req, " method"}, 32'(q_method), 32'(em));
    chk(q_subch === es && q_hold === eh, {req, " subch/hold"}, {q_subch, q_hold}, {es, eh});
    chk(q_param === d, "R2 param", q_param, d);
    tick(); word_valid = 0; exp_cnt++;
    chk(shadow_word === d, "R9 shadow", shadow_word, d);
    chk(word_count === CW'(exp_cnt), "R11 count", 32'(word_count), 32'(exp_cnt));
  endtask

  // Offer a word that must be refused; check nothing changes.
  task automatic push_blocked(input string req);
    logic [DW-1:0] sh;
    sh = shadow_word;
    word_valid = 1; word_data = 32'hBAD0_0000 + 32'(checks); #1;
    chk(word_ready === 1'b0 && q_wr === 1'b0, {req, " ready/q_wr"}, {word_ready, q_wr}, 0);
    tick(); word_valid = 0;
    chk(word_count === CW'(exp_cnt), {req, " count held"}, 32'(word_count), 32'(exp_cnt));
    chk(shadow_word === sh, {req, " shadow held"}, shadow_word, sh);
  endtask

  task automatic t_reset();
    chk(ctrl_rdata === 32'h100, "R1 R7 ctrl reset", ctrl_rdata, 32'h100);
    chk(irq_pending === 0 && word_count === 0 && shadow_word === 0, "R1 state",
        {irq_pending, word_count}, 0);
    push_en = 1; #1;
    chk(word_ready === 0, "R1 ready low", 32'(word_ready), 0);
    chk(q_method === 0, "R1 method", 32'(q_method), 0);
  endtask

  task automatic t_incr();
    csr_write(32'h1);
    chk(ctrl_rdata === 32'h101, "R7 access bit", ctrl_rdata, 32'h101);
    q_empty = 0; #1;
    chk(ctrl_rdata === 32'h001, "R7 empty bit", ctrl_rdata, 32'h001);
    q_empty = 1;
    load_hdr(14'h0100, 3'd3, 1'b0);
    push_ok(32'h1111_0001, 14'h0100, 3'd3, 0, "R2 R3 w0");
    push_ok(32'h2222_0002, 14'h0104, 3'd3, 0, "R3 w1");
    push_ok(32'h3333_0003, 14'h0108, 3'd3, 0, "R3 w2");
  endtask

  task automatic t_hold();
    load_hdr(14'h0200, 3'd5, 1'b1);
    push_ok(32'hAAAA_5555, 14'h0200, 3'd5, 1, "R4 w0");
    push_ok(32'h5555_AAAA, 14'h0200, 3'd5, 1, "R4 w1");
  endtask

  task automatic t_wrap();
    load_hdr(14'h3FFC, 3'd1, 1'b0);
    push_ok(32'h0000_00F1, 14'h3FFC, 3'd1, 0, "R3 top");
    push_ok(32'h0000_00F2, 14'h0000, 3'd1, 0, "R3 wrap");
  endtask

  task automatic t_full();
    q_full = 1;
    push_blocked("R10 full");
    push_blocked("R10 full again");
    q_full = 0;
    push_ok(32'hFEED_0001, 14'h0004, 3'd1, 0, "R10 after full");
  endtask

  task automatic t_disable();
    push_en = 0;
    push_blocked("R5 push_en off");
    push_en = 1;
    csr_write(32'h0);
    push_blocked("R5 access off");
    csr_write(32'h1);
    push_ok(32'hFEED_0002, 14'h0008, 3'd1, 0, "R5 re-enabled");
  endtask

  task automatic t_error();
    err_valid = 1; err_code = 0; tick(); err_valid = 0;
    chk(ctrl_rdata === 32'h101 && irq_pending === 0, "R6 zero code ignored",
        {irq_pending, ctrl_rdata[30:0]}, 32'h101);
    err_valid = 1; err_code = 3'd3; tick(); err_valid = 0; err_code = 0;
    chk(ctrl_rdata === 32'h1101, "R6 R7 suspended bit", ctrl_rdata, 32'h1101);
    chk(irq_pending === 1, "R6 irq set", 32'(irq_pending), 1);
    push_blocked("R5 suspended");
    csr_write(32'h1001);
    chk(ctrl_rdata[12] === 1'b1, "R8 stays suspended", 32'(ctrl_rdata[12]), 1);
    csr_write(32'h1);
    chk(ctrl_rdata === 32'h101, "R8 resume", ctrl_rdata, 32'h101);
    push_ok(32'hC0DE_0001, 14'h000C, 3'd1, 0, "R8 push after resume");
    irq_clr = 1; tick(); irq_clr = 0;
    chk(irq_pending === 0, "R12 irq cleared", 32'(irq_pending), 0);
    chk(ctrl_rdata === 32'h101, "R12 suspend unaffected", ctrl_rdata, 32'h101);
    csr_write(32'h1001);
    chk(ctrl_rdata === 32'h1101 && irq_pending === 0, "R8 forced suspend",
        {irq_pending, ctrl_rdata[30:0]}, 32'h1101);
    push_blocked("R8 forced");
  endtask

  task automatic t_priority();
    csr_write(32'h1);
    err_valid = 1; err_code = 3'd1; irq_clr = 1; csr_wr = 1; csr_wdata = 32'h1;
    tick();
    err_valid = 0; err_code = 0; irq_clr = 0; csr_wr = 0; csr_wdata = 0;
    chk(irq_pending === 1, "R12 error beats clear", 32'(irq_pending), 1);
    chk(ctrl_rdata[12] === 1'b1, "R8 error beats resume", 32'(ctrl_rdata[12]), 1);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_incr();
    t_hold();
    t_wrap();
    t_full();
    t_disable();
    t_error();
    t_priority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule